// File: doc/BRIEF.md
# Single-Shot Fourth-Order Decimation Filter

This block turns the one-bit output stream of a delta-sigma modulator into a single signed conversion result. A conversion begins on a start pulse. Each sample that arrives with its valid strobe is mapped to +1 (bit high) or -1 (bit low). The sample then passes through a chain of four moving-sum sections, which together form a fourth-order sinc-type weighting. When the last sample of the window has been taken, the final sum is scaled to a 22-bit two's-complement word and latched, and a ready flag goes high. Every accumulator is cleared at that point, so the next conversion starts from zero.

Each of the four section lengths is a parameter. Equal lengths place all transfer-function zeros at one frequency. Unequal lengths spread the zeros, which widens the rejection notch so that it can cover two nearby line frequencies at once. A conversion consumes the sum of the four lengths minus three samples: 509 samples with the default length of 128 per section. After a wake pulse, which signals that the modulator has just left its powered-down state, the next conversion holds back its ready flag for a fixed number of extra clock cycles.

Top module: `sinc_oneshot`

## Requirements
- R1: After reset, `readyOut` is 0 and `dataOut` is 0.
- R2: The result equals sat(floor((y + 2^(S-1)) / 2^S)). Here y = sum over k of h[k]·x[N-1-k], where x is +1 for a 1 bit and -1 for a 0 bit, h is the convolution of four all-ones windows with the four section lengths, N is the window length, and S = (sum of ceil(log2) of the lengths) - (OUT_W - 1).
- R3: A conversion accepts exactly L1+L2+L3+L4-3 samples, which is 509 by default. `readyOut` is still 0 after the second-to-last accepted sample and is 1 in the cycle after the edge that accepts the last one.
- R4: The output saturates. With default parameters, all-ones input gives 0x1FFFFF (2097151) and all-zeros input gives 0x200000 (-2097152).
- R5: `startIn` clears `readyOut` at the next edge and discards any partial accumulation. A sample presented in the same cycle as `startIn` is not used.
- R6: Once `readyOut` is high, it stays high and `dataOut` stays constant until `startIn` or `ackIn`. `ackIn` drops `readyOut` at the next edge without changing `dataOut`.
- R7: Samples that arrive while no conversion is running (idle, result pending, or holdoff) change neither the outputs nor the next conversion's result.
- R8: All section state is cleared after each result, so two conversions of the same stream give identical results.
- R9: After a `wakeIn` pulse, the next conversion raises `readyOut` exactly WAKE_EXTRA (144) cycles later than normal. The conversions after it use normal timing.
- R10: The section lengths are set per section. With lengths 5, 6, 7 and 8 and OUT_W of 10, a conversion takes 23 samples and follows the R2 formula.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bitValid | input | 1 | Marks a modulator sample on `bitIn` |
| bitIn | input | 1 | Modulator output bit |
| startIn | input | 1 | Begins a new conversion (aborts any in progress) |
| ackIn | input | 1 | Acknowledges the pending result, clearing ready |
| wakeIn | input | 1 | Pulse marking exit from powered-down state |
| dataOut | output | OUT_W | Signed conversion result |
| readyOut | output | 1 | Result available |

## Verification
The hardest case to reach from the ports is the wake holdoff. It only appears once a whole 509-sample window has completed after a wake pulse. Its timing has to be measured from an edge that leaves no trace at the outputs, the acceptance of the final sample. The bench counts accepted samples itself and checks that ready is still low exactly one cycle before the 144-cycle boundary and high exactly at it. It then runs a further conversion to show that the penalty does not repeat. Leaks through the circular history buffers are caught in a similar way. Stray samples are fed while idle, a run is aborted partway, and the same stream is converted again, so any leftover state would shift the computed weighting away from the independent convolution model.

// File: rtl/sinc_oneshot_pkg.sv
package sinc_oneshot_pkg;
  // Strobes from the sequencer to the arithmetic path.
  typedef struct packed {
    logic clear;    // zero all section state
    logic accept;   // fold the present sample into the sections
    logic capture;  // latch the scaled final sum
  } sincStrobe_t;
endpackage

// File: rtl/sinc_boxcar.sv
// One moving-sum section: running sum over the last LEN inputs,
// with a circular history that reads as zero until it has filled.
module sinc_boxcar #(
  parameter int LEN   = 128,
  parameter int IN_W  = 2,
  parameter int OUT_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    accept,
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] sumNext
);
  localparam int PTR_W = (LEN > 1) ? $clog2(LEN) : 1;

  logic signed [IN_W-1:0]  hist [LEN];
  logic [PTR_W-1:0]        ptr;
  logic                    full;
  logic signed [OUT_W-1:0] sum;
  logic signed [IN_W-1:0]  leaving;
  logic                    wrap;

  assign wrap    = (ptr == PTR_W'(LEN - 1));
  assign leaving = full ? hist[ptr] : '0;
  assign sumNext = sum + OUT_W'(din) - OUT_W'(leaving);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum  <= '0;
      ptr  <= '0;
      full <= 1'b0;
    end else if (clear) begin
      sum  <= '0;
      ptr  <= '0;
      full <= 1'b0;
    end else if (accept) begin
      sum <= sumNext;
      ptr <= wrap ? '0 : ptr + 1'b1;
      if (wrap) full <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept && !clear) hist[ptr] <= din;
  end
endmodule

// File: rtl/sinc_ctrl.sv
// Sequencer: counts the samples of one conversion, applies the
// post-wake holdoff and holds the ready state until released.
module sinc_ctrl
  import sinc_oneshot_pkg::*;
#(
  parameter int NSAMP      = 509,
  parameter int WAKE_EXTRA = 144
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bitValid,
  input  logic        startIn,
  input  logic        ackIn,
  input  logic        wakeIn,
  output sincStrobe_t strb,
  output logic        readyOut
);
  localparam int CNT_W = (NSAMP > 1) ? $clog2(NSAMP) : 1;
  localparam int HC_W  = (WAKE_EXTRA > 1) ? $clog2(WAKE_EXTRA) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD, ST_DONE} seqState_t;

  seqState_t       state;
  logic [CNT_W-1:0] sampleCnt;
  logic [HC_W-1:0]  holdCnt;
  logic             wakePending;
  logic             accept, lastSample, holdDone, goHold;

  assign accept     = (state == ST_RUN) && bitValid && !startIn;
  assign lastSample = accept && (sampleCnt == CNT_W'(NSAMP - 1));
  assign holdDone   = (state == ST_HOLD) && (holdCnt == HC_W'(WAKE_EXTRA - 1)) && !startIn;
  assign goHold     = wakePending && (WAKE_EXTRA != 0);

  always_comb begin
    strb.accept  = accept;
    strb.capture = lastSample;
    strb.clear   = startIn || lastSample;
  end

  assign readyOut = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      sampleCnt   <= '0;
      holdCnt     <= '0;
      wakePending <= 1'b0;
    end else begin
      wakePending <= wakeIn || (wakePending && !holdDone);
      if (startIn) begin
        state     <= ST_RUN;
        sampleCnt <= '0;
        holdCnt   <= '0;
      end else begin
        unique case (state)
          ST_RUN: if (accept) begin
            if (lastSample) begin
              sampleCnt <= '0;
              holdCnt   <= '0;
              state     <= goHold ? ST_HOLD : ST_DONE;
            end else begin
              sampleCnt <= sampleCnt + 1'b1;
            end
          end
          ST_HOLD: begin
            holdCnt <= holdCnt + 1'b1;
            if (holdDone) state <= ST_DONE;
          end
          ST_DONE: if (ackIn) state <= ST_IDLE;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sinc_datapath.sv
// Four chained moving-sum sections, output rounding, saturation and
// the result register.
module sinc_datapath
  import sinc_oneshot_pkg::*;
#(
  parameter int L1    = 128,
  parameter int L2    = 128,
  parameter int L3    = 128,
  parameter int L4    = 128,
  parameter int OUT_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sincStrobe_t       strb,
  input  logic              bitIn,
  output logic [OUT_W-1:0]  dataOut
);
  localparam int LEN_A [4] = '{L1, L2, L3, L4};

  function automatic int stageW(int k);
    int w = 2;
    for (int i = 0; i <= k; i++) w += $clog2(LEN_A[i]);
    return w;
  endfunction

  localparam int W4    = stageW(3);
  localparam int FS    = W4 - 2;             // log2 of full-scale sum
  localparam int SHIFT = FS - (OUT_W - 1);   // must be at least 1
  localparam logic signed [W4:0] HALF    = (W4+1)'(longint'(1) <<< (SHIFT - 1));
  localparam logic signed [W4:0] POS_LIM = (W4+1)'((longint'(1) <<< (OUT_W - 1)) - 1);
  localparam logic signed [W4:0] NEG_LIM = (W4+1)'(-(longint'(1) <<< (OUT_W - 1)));

  for (genvar k = 0; k < 4; k++) begin : g_stage
    localparam int IW = (k == 0) ? 2 : stageW(k - 1);
    localparam int OW = stageW(k);
    logic signed [IW-1:0] din;
    logic signed [OW-1:0] sn;
    if (k == 0) begin : g_src
      assign din = bitIn ? 2'sb01 : 2'sb11;
    end else begin : g_link
      assign din = g_stage[k-1].sn;
    end
    sinc_boxcar #(.LEN(LEN_A[k]), .IN_W(IW), .OUT_W(OW)) u_box (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (strb.clear),
      .accept  (strb.accept),
      .din     (din),
      .sumNext (sn)
    );
  end

  logic signed [W4:0]    biased, shifted;
  logic [OUT_W-1:0]      satVal;

  always_comb begin
    biased  = (W4+1)'(g_stage[3].sn) + HALF;
    shifted = biased >>> SHIFT;
    if (shifted > POS_LIM)      satVal = POS_LIM[OUT_W-1:0];
    else if (shifted < NEG_LIM) satVal = NEG_LIM[OUT_W-1:0];
    else                        satVal = shifted[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             dataOut <= '0;
    else if (strb.capture)  dataOut <= satVal;
  end
endmodule

// File: rtl/sinc_oneshot.sv
module sinc_oneshot
  import sinc_oneshot_pkg::*;
#(
  parameter int L1         = 128,
  parameter int L2         = 128,
  parameter int L3         = 128,
  parameter int L4         = 128,
  parameter int OUT_W      = 22,
  parameter int WAKE_EXTRA = 144
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bitValid,
  input  logic             bitIn,
  input  logic             startIn,
  input  logic             ackIn,
  input  logic             wakeIn,
  output logic [OUT_W-1:0] dataOut,
  output logic             readyOut
);
  localparam int NSAMP = L1 + L2 + L3 + L4 - 3;

  sincStrobe_t strb;

  sinc_ctrl #(.NSAMP(NSAMP), .WAKE_EXTRA(WAKE_EXTRA)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .bitValid (bitValid),
    .startIn  (startIn),
    .ackIn    (ackIn),
    .wakeIn   (wakeIn),
    .strb     (strb),
    .readyOut (readyOut)
  );

  sinc_datapath #(.L1(L1), .L2(L2), .L3(L3), .L4(L4), .OUT_W(OUT_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .bitIn   (bitIn),
    .dataOut (dataOut)
  );
endmodule

// File: rtl/sinc_oneshot_chk.sv
module sinc_oneshot_chk
  import sinc_oneshot_pkg::*;
#(
  parameter int NSAMP      = 509,
  parameter int WAKE_EXTRA = 144,
  parameter int OUT_W      = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bitValid,
  input logic             startIn,
  input logic             ackIn,
  input logic             readyOut,
  input logic [OUT_W-1:0] dataOut,
  input sincStrobe_t      strb
);
  int acceptCnt;
  int gapCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acceptCnt <= 0;
      gapCnt    <= 1 << 20;
    end else begin
      if (strb.clear)       acceptCnt <= 0;
      else if (strb.accept) acceptCnt <= acceptCnt + 1;
      if (strb.capture)          gapCnt <= 0;
      else if (gapCnt < (1 << 20)) gapCnt <= gapCnt + 1;
    end
  end

  p_window_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture |-> (acceptCnt == NSAMP - 1));

  p_ready_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(readyOut) |-> (gapCnt == 0 || gapCnt == WAKE_EXTRA));

  p_start_drops_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    startIn |=> !readyOut);

  p_ack_drops_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ackIn |=> !readyOut);

  p_result_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (readyOut && $past(readyOut)) |-> $stable(dataOut));

  p_accept_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.accept |-> (bitValid && !startIn && !readyOut));
endmodule

bind sinc_oneshot sinc_oneshot_chk #(
  .NSAMP(NSAMP), .WAKE_EXTRA(WAKE_EXTRA), .OUT_W(OUT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bitValid (bitValid),
  .startIn  (startIn),
  .ackIn    (ackIn),
  .readyOut (readyOut),
  .dataOut  (dataOut),
  .strb     (strb)
);

// File: tb/sinc_oneshot_test.sv
`timescale 1ns/1ps
module sinc_oneshot_test;
  localparam int N_MAIN = 509;
  localparam int N_STAG = 23;
  localparam int HOLD   = 144;
  // per-vector: period, ones per period, phase, sample spacing
  localparam int VEC [8][4] = '{
    '{1, 1, 0, 1}, '{1, 0, 0, 1}, '{2, 1, 0, 1}, '{4, 3, 1, 4},
    '{7, 2, 3, 1}, '{5, 4, 0, 2}, '{3, 1, 2, 1}, '{2, 1, 0, 1}
  };

  logic clk = 1'b0;
  logic rst_n, bitValid, bitIn, startIn, ackIn, wakeIn;
  logic [21:0] dataOut;
  logic        readyOut;
  logic [9:0]  sData;
  logic        sReady;
  int nChecks = 0;
  int nFails  = 0;
  longint res [8];

  always #2 clk = ~clk;

  sinc_oneshot uut (
    .clk(clk), .rst_n(rst_n), .bitValid(bitValid), .bitIn(bitIn),
    .startIn(startIn), .ackIn(ackIn), .wakeIn(wakeIn),
    .dataOut(dataOut), .readyOut(readyOut)
  );

  sinc_oneshot #(.L1(5), .L2(6), .L3(7), .L4(8), .OUT_W(10), .WAKE_EXTRA(HOLD)) uutStag (
    .clk(clk), .rst_n(rst_n), .bitValid(bitValid), .bitIn(bitIn),
    .startIn(startIn), .ackIn(ackIn), .wakeIn(wakeIn),
    .dataOut(sData), .readyOut(sReady)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit patBit(int per, int ones, int phase, int i);
    return ((i + phase) % per) < ones;
  endfunction

  // Independent model: direct convolution of four windows, then dot product.
  function automatic longint model(int a, int b, int c, int d, int outW,
                                   int per, int ones, int phase);
    int h [0:519];
    int t [0:519];
    int lens [4];
    int len, n, fs, s;
    longint y, r, lim;
    lens = '{a, b, c, d};
    for (int i = 0; i < 520; i++) h[i] = 0;
    for (int i = 0; i < a; i++) h[i] = 1;
    len = a;
    for (int st = 1; st < 4; st++) begin
      for (int j = 0; j < len + lens[st] - 1; j++) begin
        t[j] = 0;
        for (int m = 0; m < len; m++)
          if (j - m >= 0 && j - m < lens[st]) t[j] += h[m];
      end
      len = len + lens[st] - 1;
      for (int j = 0; j < len; j++) h[j] = t[j];
    end
    n = len;
    y = 0;
    for (int k = 0; k < n; k++)
      y += longint'(h[k]) * (patBit(per, ones, phase, n - 1 - k) ? 1 : -1);
    fs = $clog2(a) + $clog2(b) + $clog2(c) + $clog2(d);
    s = fs - (outW - 1);
    r = (y + (longint'(1) <<< (s - 1))) >>> s;
    lim = longint'(1) <<< (outW - 1);
    if (r > lim - 1) r = lim - 1;
    if (r < -lim) r = -lim;
    return r;
  endfunction

  task automatic runConv(input int per, input int ones, input int phase,
                         input int spacing, input int hold, input bit chkStag,
                         output longint got);
    longint sExp;
    sExp = model(5, 6, 7, 8, 10, per, ones, phase);
    @(negedge clk);
    startIn = 1'b1; bitValid = 1'b1; bitIn = 1'b1;  // R5: this sample is dropped
    @(negedge clk);
    startIn = 1'b0; bitValid = 1'b0;
    check(readyOut == 1'b0, "R5", "ready after start", longint'(readyOut), 0);
    for (int i = 0; i < N_MAIN; i++) begin
      bitValid = 1'b1;
      bitIn = patBit(per, ones, phase, i);
      @(negedge clk);
      bitValid = 1'b0;
      if (chkStag && i == N_STAG - 1) begin
        check(sReady == 1'b1, "R10", "staggered ready", longint'(sReady), 1);
        check(longint'($signed(sData)) == sExp, "R10", "staggered result",
              longint'($signed(sData)), sExp);
      end
      if (i == N_MAIN - 2)
        check(readyOut == 1'b0, "R3", "ready before last sample", longint'(readyOut), 0);
      if (i < N_MAIN - 1) repeat (spacing - 1) @(negedge clk);
    end
    if (hold == 0) begin
      check(readyOut == 1'b1, "R3", "ready after last sample", longint'(readyOut), 1);
    end else begin
      check(readyOut == 1'b0, "R9", "ready held at window end", longint'(readyOut), 0);
      repeat (hold - 1) @(negedge clk);
      check(readyOut == 1'b0, "R9", "ready one cycle before holdoff end", longint'(readyOut), 0);
      @(negedge clk);
      check(readyOut == 1'b1, "R9", "ready at holdoff end", longint'(readyOut), 1);
    end
    got = longint'($signed(dataOut));
    check(got == model(128, 128, 128, 128, 22, per, ones, phase), "R2", "result",
          got, model(128, 128, 128, 128, 22, per, ones, phase));
    if (chkStag)
      check(longint'($signed(sData)) == sExp, "R7", "staggered result after late samples",
            longint'($signed(sData)), sExp);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    longint got, held;
    rst_n = 1'b0; bitValid = 1'b0; bitIn = 1'b0;
    startIn = 1'b0; ackIn = 1'b0; wakeIn = 1'b0;
    repeat (5) @(negedge clk);
    check(readyOut == 1'b0, "R1", "ready in reset", longint'(readyOut), 0);
    check(dataOut == 22'd0, "R1", "data in reset", longint'(dataOut), 0);
    check(sReady == 1'b0, "R1", "staggered ready in reset", longint'(sReady), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 8; v++)
      runConv(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 0, 1'b1, res[v]);
    check(res[0] == 2097151, "R4", "positive saturation", res[0], 2097151);
    check(res[1] == -2097152, "R4", "negative saturation", res[1], -2097152);
    check(res[7] == res[2], "R8", "repeat conversion matches", res[7], res[2]);

    // R6: result held, then acknowledged
    repeat (25) @(negedge clk);
    check(readyOut == 1'b1, "R6", "ready held", longint'(readyOut), 1);
    check(longint'($signed(dataOut)) == res[7], "R6", "data held",
          longint'($signed(dataOut)), res[7]);
    ackIn = 1'b1; @(negedge clk); ackIn = 1'b0;
    check(readyOut == 1'b0, "R6", "ready after ack", longint'(readyOut), 0);
    check(longint'($signed(dataOut)) == res[7], "R6", "data after ack",
          longint'($signed(dataOut)), res[7]);

    // R7: samples while idle are dropped
    for (int i = 0; i < 300; i++) begin
      bitValid = 1'b1; bitIn = 1'b1; @(negedge clk);
    end
    bitValid = 1'b0;
    check(readyOut == 1'b0, "R7", "ready after idle samples", longint'(readyOut), 0);
    check(longint'($signed(dataOut)) == res[7], "R7", "data after idle samples",
          longint'($signed(dataOut)), res[7]);
    runConv(2, 1, 0, 1, 0, 1'b1, got);
    check(got == res[2], "R7", "no leak from idle samples", got, res[2]);
    held = got;
    for (int i = 0; i < 100; i++) begin
      bitValid = 1'b1; bitIn = 1'b0; @(negedge clk);
    end
    bitValid = 1'b0;
    check(longint'($signed(dataOut)) == held, "R7", "data after samples while ready",
          longint'($signed(dataOut)), held);
    check(readyOut == 1'b1, "R7", "ready after samples while ready", longint'(readyOut), 1);

    // R5: abort a partial conversion
    startIn = 1'b1; @(negedge clk); startIn = 1'b0;
    for (int i = 0; i < 200; i++) begin
      bitValid = 1'b1; bitIn = 1'b1; @(negedge clk);
    end
    bitValid = 1'b0;
    runConv(3, 1, 2, 1, 0, 1'b1, got);
    check(got == res[6], "R5", "restart discards partial sum", got, res[6]);

    // R9: wake holdoff on first conversion only
    wakeIn = 1'b1; @(negedge clk); wakeIn = 1'b0;
    runConv(4, 3, 1, 1, HOLD, 1'b0, got);
    check(got == res[3], "R9", "result after holdoff", got, res[3]);
    runConv(7, 2, 3, 1, 0, 1'b1, got);
    check(got == res[4], "R9", "next conversion normal timing", got, res[4]);

    finishRun();
  end
endmodule